// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits in front of the main instruction decoder and turns a 16-bit compressed instruction into its single full-length 32-bit equivalent. It is purely combinational, so the expanded word is ready in the same decode cycle that presents the compressed word. Each compressed form has exactly one expansion.

The compressed opcode is a prefix code read from bit 15 downward and is 1, 3, 4, 6 or 7 bits long. After decoding it, the expander extracts the register fields and the 8-bit immediate. It widens a 2-bit destination selector into one of four fixed registers. It supplies implied operands, namely a zero base register for load-immediate and the constants 0 and 4 for the move and step forms. It also flags the mode-return and no-op forms for the fetch logic, and it raises an illegal flag when the reserved bits of a 7-bit form are not zero.

The output uses one internal format:
- major opcode in bits [31:26];
- destination register in bits [25:21];
- first source in bits [20:16];
- second source in bits [15:11], with bits [10:0] zero;
- for immediate forms, the 16-bit immediate in bits [15:0].

Top module: `cx_expander`

## Requirements
- R1: The opcode prefix selects the form:
  - `0` add-immediate;
  - `100` compare-immediate;
  - `101` load-immediate;
  - `1100` subtract-from, `1101` add, `1110` shift-left;
  - `111100` add-zero, `111101` add-four, `111110` compare-register;
  - `1111110` mode-return, `1111111` no-op.

  The major opcodes emitted are 14 for the add-immediate family, 11 for compare-immediate, 40/41/42/43 for subtract-from/add/shift-left/compare-register, and 50 for mode-return.
- R2: Add-immediate takes its destination selector from bits [14:13], its source from [12:8] and its immediate from [7:0]. It expands to major 14 with rd = 24 + selector, ra = source, and the immediate sign-extended.
- R3: Compare-immediate expands to major 11 with rd = 0, ra = [12:8] and the sign-extended immediate from [7:0]. Load-immediate expands to major 14 with rd = [12:8], ra = 0 and the sign-extended immediate.
- R4: Subtract-from, add and shift-left take the selector from [11:10], the first source from [9:5] and the second source from [4:0]. They expand to rd = 24 + selector, ra = first source, rb = second source, with bits [10:0] zero.
- R5: Add-zero and add-four expand to major 14 with rd = [9:5], ra = [4:0] and an immediate of 0 or 4 respectively.
- R6: Compare-register expands to major 43 with rd = 0, ra = [9:5], rb = [4:0] and bits [10:0] zero.
- R7: When bits [8:0] are zero, mode-return outputs major 50 with all other bits zero and sets only the mode-return flag. Under the same condition, no-op outputs 0x38000000 and sets only the no-op flag.
- R8: A 7-bit form with any of bits [8:0] set raises only the illegal flag and drives an all-zero word. No other encoding raises a flag.
- R9: The 8-bit immediate is treated as signed (-128 to +127), and bits [15:8] of the expanded immediate copy its bit 7.
- R10: The output is a combinational function of the input and holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cinsn_i | input | 16 | Compressed instruction |
| xinsn_o | output | 32 | Expanded full-length instruction |
| mode_ret_o | output | 1 | Compressed word is a mode-return |
| nop_o | output | 1 | Compressed word is a padding no-op |
| illegal_o | output | 1 | Reserved bits set in a 7-bit form |

## Verification
The bench builds the block with its default parameters: a 16-bit input, a 32-bit output, 5-bit registers, a 2-bit restricted selector based at register 24, and an 8-bit immediate. With these values the input space is only 65536 words, so every compressed encoding is applied and compared against an arithmetic model. The sweep therefore reaches every prefix boundary, all four restricted registers, both immediate extremes and every reserved-bit pattern of the two 7-bit forms.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [3:0] {
    K_ADDI, K_CMPI, K_LI, K_SUBF, K_ADD, K_SLW,
    K_ADD0, K_ADD4, K_CMPW, K_MRET, K_NOP
  } ckind_t;

  localparam logic [5:0] MAJ_ADDI = 6'd14;
  localparam logic [5:0] MAJ_CMPI = 6'd11;
  localparam logic [5:0] MAJ_SUBF = 6'd40;
  localparam logic [5:0] MAJ_ADD  = 6'd41;
  localparam logic [5:0] MAJ_SLW  = 6'd42;
  localparam logic [5:0] MAJ_CMPW = 6'd43;
  localparam logic [5:0] MAJ_MRET = 6'd50;

  localparam int LONGEST_OP = 7;
endpackage

// File: rtl/cx_prefix_dec.sv
module cx_prefix_dec
  import cx_pkg::*;
#(
  parameter int ILEN = 16
) (
  input  logic [ILEN-1:0] cinsn_i,
  output ckind_t          kind_o,
  output logic            rsv_bad_o
);
  localparam int RSV_W = ILEN - LONGEST_OP;

  logic [LONGEST_OP-1:0] pfx;
  assign pfx = cinsn_i[ILEN-1 -: LONGEST_OP];

  always_comb begin
    kind_o = K_NOP;
    casez (pfx)
      7'b0??????: kind_o = K_ADDI;
      7'b100????: kind_o = K_CMPI;
      7'b101????: kind_o = K_LI;
      7'b1100???: kind_o = K_SUBF;
      7'b1101???: kind_o = K_ADD;
      7'b1110???: kind_o = K_SLW;
      7'b111100?: kind_o = K_ADD0;
      7'b111101?: kind_o = K_ADD4;
      7'b111110?: kind_o = K_CMPW;
      7'b1111110: kind_o = K_MRET;
      default:    kind_o = K_NOP;
    endcase
  end

  assign rsv_bad_o = (kind_o == K_MRET || kind_o == K_NOP) &&
                     (cinsn_i[RSV_W-1:0] != '0);
endmodule

// File: rtl/cx_reg_widen.sv
module cx_reg_widen #(
  parameter int RSEL_W = 2,
  parameter int REG_W  = 5,
  parameter int RBASE  = 24
) (
  input  logic [RSEL_W-1:0] sel_i,
  output logic [REG_W-1:0]  reg_o
);
  localparam logic [REG_W-1:0] BASE_V = REG_W'(RBASE);

  assign reg_o = BASE_V + REG_W'(sel_i);
endmodule

// File: rtl/cx_imm_ext.sv
module cx_imm_ext #(
  parameter int IMM_W  = 8,
  parameter int XIMM_W = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  output logic [XIMM_W-1:0] imm_o
);
  localparam int PAD_W = XIMM_W - IMM_W;

  assign imm_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int ILEN    = 16,
  parameter int XLEN    = 32,
  parameter int OPC_W   = 6,
  parameter int REG_W   = 5,
  parameter int RSEL_W  = 2,
  parameter int RBASE   = 24,
  parameter int IMM_W   = 8,
  parameter int XIMM_W  = 16,
  parameter int OPC_LSB = 26,
  parameter int RD_LSB  = 21,
  parameter int RA_LSB  = 16,
  parameter int RB_LSB  = 11,
  parameter int IMM_LSB = 0
) (
  input  logic [ILEN-1:0] cinsn_i,
  output logic [XLEN-1:0] xinsn_o,
  output logic            mode_ret_o,
  output logic            nop_o,
  output logic            illegal_o
);
  localparam int LSEL_HI = ILEN - 2;
  localparam int RSEL_HI = ILEN - 5;
  localparam int SRC_HI  = IMM_W + REG_W - 1;
  localparam int PAD_W   = XIMM_W - IMM_W;
  localparam logic [REG_W-1:0] RLOW = REG_W'(RBASE);
  localparam logic [REG_W-1:0] RTOP = REG_W'(RBASE + (1 << RSEL_W) - 1);

  ckind_t kind;
  logic   rsv_bad;

  cx_prefix_dec #(.ILEN(ILEN)) u_dec (
    .cinsn_i  (cinsn_i),
    .kind_o   (kind),
    .rsv_bad_o(rsv_bad)
  );

  logic             use_long_sel;
  logic [RSEL_W-1:0] rsel;
  logic [REG_W-1:0]  rwide;

  assign use_long_sel = (kind == K_ADDI);
  assign rsel = use_long_sel ? cinsn_i[LSEL_HI -: RSEL_W]
                             : cinsn_i[RSEL_HI -: RSEL_W];

  cx_reg_widen #(.RSEL_W(RSEL_W), .REG_W(REG_W), .RBASE(RBASE)) u_widen (
    .sel_i(rsel),
    .reg_o(rwide)
  );

  logic [XIMM_W-1:0] simm;

  cx_imm_ext #(.IMM_W(IMM_W), .XIMM_W(XIMM_W)) u_ext (
    .imm_i(cinsn_i[IMM_W-1:0]),
    .imm_o(simm)
  );

  logic [REG_W-1:0] f_hi, f_a, f_b;
  assign f_hi = cinsn_i[SRC_HI -: REG_W];
  assign f_a  = cinsn_i[2*REG_W-1 -: REG_W];
  assign f_b  = cinsn_i[REG_W-1:0];

  logic [OPC_W-1:0]  maj;
  logic [REG_W-1:0]  rd, ra, rb;
  logic [XIMM_W-1:0] imm;
  logic              has_imm;

  always_comb begin
    maj = '0; rd = '0; ra = '0; rb = '0; imm = '0; has_imm = 1'b0;
    case (kind)
      K_ADDI: begin maj = MAJ_ADDI; rd = rwide; ra = f_hi; imm = simm; has_imm = 1'b1; end
      K_CMPI: begin maj = MAJ_CMPI; ra = f_hi; imm = simm; has_imm = 1'b1; end
      K_LI:   begin maj = MAJ_ADDI; rd = f_hi; imm = simm; has_imm = 1'b1; end
      K_SUBF: begin maj = MAJ_SUBF; rd = rwide; ra = f_a; rb = f_b; end
      K_ADD:  begin maj = MAJ_ADD;  rd = rwide; ra = f_a; rb = f_b; end
      K_SLW:  begin maj = MAJ_SLW;  rd = rwide; ra = f_a; rb = f_b; end
      K_ADD0: begin maj = MAJ_ADDI; rd = f_a; ra = f_b; has_imm = 1'b1; end
      K_ADD4: begin maj = MAJ_ADDI; rd = f_a; ra = f_b; imm = XIMM_W'(4); has_imm = 1'b1; end
      K_CMPW: begin maj = MAJ_CMPW; ra = f_a; rb = f_b; end
      K_MRET: begin maj = rsv_bad ? '0 : MAJ_MRET; end
      default: begin maj = rsv_bad ? '0 : MAJ_ADDI; has_imm = 1'b1; end
    endcase
  end

  always_comb begin
    xinsn_o = '0;
    xinsn_o[OPC_LSB +: OPC_W] = maj;
    xinsn_o[RD_LSB  +: REG_W] = rd;
    xinsn_o[RA_LSB  +: REG_W] = ra;
    if (has_imm) xinsn_o[IMM_LSB +: XIMM_W] = imm;
    else         xinsn_o[RB_LSB  +: REG_W]  = rb;
  end

  assign mode_ret_o = (kind == K_MRET) && !rsv_bad;
  assign nop_o      = (kind == K_NOP)  && !rsv_bad;
  assign illegal_o  = rsv_bad;

  always_comb begin
    if (!$isunknown(cinsn_i)) begin
      // R8
      illegal_zero_chk: assert (!illegal_o || xinsn_o == '0);
      // R7
      flag_excl_chk: assert ($onehot0({mode_ret_o, nop_o, illegal_o}));
      // R7
      mret_rsv_chk: assert (!mode_ret_o || cinsn_i[ILEN-LONGEST_OP-1:0] == '0);
      // R4
      rd_window_chk: assert (!(kind == K_ADDI || kind == K_SUBF || kind == K_ADD ||
                               kind == K_SLW) ||
                             (xinsn_o[RD_LSB +: REG_W] >= RLOW &&
                              xinsn_o[RD_LSB +: REG_W] <= RTOP));
      // R9
      sext_chk: assert (!(kind == K_ADDI || kind == K_CMPI || kind == K_LI) ||
                        xinsn_o[IMM_LSB+IMM_W +: PAD_W] ==
                        {PAD_W{xinsn_o[IMM_LSB+IMM_W-1]}});
    end
  end
endmodule

// File: tb/sim_cx_expander.sv
module sim_cx_expander;
  logic        clk;
  logic [15:0] cin;
  logic [31:0] xout;
  logic        mret, nop, ill;
  int          n_run, n_fail;
  bit          done;

  cx_expander u0 (
    .cinsn_i   (cin),
    .xinsn_o   (xout),
    .mode_ret_o(mret),
    .nop_o     (nop),
    .illegal_o (ill)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model(input logic [15:0] c, output logic [31:0] w,
                       output logic m, output logic n, output logic il,
                       output string tag);
    logic [15:0] sx;
    logic [4:0]  a, b;
    sx = {{8{c[7]}}, c[7:0]};
    a = c[9:5];
    b = c[4:0];
    m = 0; n = 0; il = 0; w = '0;
    if (!c[15]) begin
      w = {6'd14, 5'(24 + c[14:13]), c[12:8], sx}; tag = "R2/R9";
    end else if (c[14:13] == 2'b00) begin
      w = {6'd11, 5'd0, c[12:8], sx}; tag = "R3/R9";
    end else if (c[14:13] == 2'b01) begin
      w = {6'd14, c[12:8], 5'd0, sx}; tag = "R3";
    end else if (c[15:12] == 4'b1100) begin
      w = {6'd40, 5'(24 + c[11:10]), a, b, 11'd0}; tag = "R4";
    end else if (c[15:12] == 4'b1101) begin
      w = {6'd41, 5'(24 + c[11:10]), a, b, 11'd0}; tag = "R4";
    end else if (c[15:12] == 4'b1110) begin
      w = {6'd42, 5'(24 + c[11:10]), a, b, 11'd0}; tag = "R4";
    end else if (c[11:10] == 2'b00) begin
      w = {6'd14, a, b, 16'd0}; tag = "R5";
    end else if (c[11:10] == 2'b01) begin
      w = {6'd14, a, b, 16'd4}; tag = "R5";
    end else if (c[11:10] == 2'b10) begin
      w = {6'd43, 5'd0, a, b, 11'd0}; tag = "R6";
    end else if (c[8:0] != 0) begin
      il = 1; tag = "R8";
    end else if (!c[9]) begin
      w = {6'd50, 26'd0}; m = 1; tag = "R7";
    end else begin
      w = 32'h3800_0000; n = 1; tag = "R7";
    end
  endtask

  task automatic check_one(input logic [15:0] v, input string extra);
    logic [31:0] ew;
    logic em, en, ei;
    string t;
    @(posedge clk);
    cin = v;
    @(negedge clk);
    model(v, ew, em, en, ei, t);
    n_run++;
    if (xout !== ew || mret !== em || nop !== en || ill !== ei) begin
      n_fail++;
      $display("FAIL %s%s in=%h got w=%h m=%b n=%b i=%b exp w=%h m=%b n=%b i=%b",
               t, extra, v, xout, mret, nop, ill, ew, em, en, ei);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    cin = '0;
    // R1 boundary prefixes and R10 same-cycle response
    check_one(16'h0000, " R1 R10");
    check_one(16'h7FFF, " R1");
    check_one(16'h8000, " R1");
    check_one(16'hFC00, " R1");
    check_one(16'hFE00, " R1");
    check_one(16'hFFFF, " R8");
    check_one(16'hFE01, " R8");
    check_one(16'h0080, " R9");
    check_one(16'h007F, " R9");
    // full sweep
    for (int i = 0; i < 65536; i++) check_one(16'(i), "");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 180000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule